// File: doc/BRIEF.md
# Retry Escalation Controller

This block supervises the error recovery of a serial link in two stages. Each CRC error seen while the link is trained asks the far end to replay, through a one-cycle retry request. A programmable number of consecutive replays is tolerated. The CRC error after that number escalates to a link reset request. Link resets caused this way are counted as well. Once their own programmable number is used up, the next escalation raises a sticky error flag, and the flag silences the block until a hard reset.

Software reaches the block through one small control register. The register holds two 2-bit limit codes, which survive soft resets, and two command bits that clear themselves. A soft command restarts the link and keeps the limit codes. A hard command restarts the link and returns everything to its power-on state. Edits to the limit codes are late acting: the controller copies them into working shadows only when a link reset begins.

Top module: `retry_escalation_ctrl`

## Requirements
- R1: Retry code (register bits [1:0]) 00, 01 and 10 allow 16, 8 and 4 consecutive replays. Each CRC error under the limit gives a one-cycle `retry_req` in the cycle after it is sampled.
- R2: A CRC error that arrives when the limit has been reached gives no `retry_req`. It gives a one-cycle `link_rst_req` and restarts the replay count from zero.
- R3: Retry code 11 disables replay: any CRC error sets `err_flag` and issues no request.
- R4: Link-reset code (register bits [3:2]) 00, 01, 10 and 11 allow 2, 1, 0 and 0 escalation resets. An escalation beyond that number sets `err_flag` instead of requesting a link reset.
- R5: A `retry_ok` pulse clears the consecutive replay count.
- R6: The escalation-reset count clears only when `retry_ok` follows a rising edge of `link_up` that comes after an escalation reset. A `retry_ok` with no such edge leaves the count alone.
- R7: `err_flag` stays set until a hard command executes. While it is set, neither CRC errors nor soft commands produce `retry_req` or `link_rst_req`.
- R8: Written limit codes take effect only at the next link reset (escalation or soft command). A hard command restores the default limits 16 and 2.
- R9: Setting the soft bit (register bit 4) gives `link_rst_req` one cycle later and clears the replay count. The limit codes are kept and the bit reads back 0 once the reset has asserted.
- R10: Setting the hard bit (register bit 5) gives `link_rst_req` one cycle later. It clears `err_flag`, both counts and both limit codes, and the bit then reads back 0.
- R11: CRC errors sampled while `link_up` is low are ignored and do not advance the replay count.
- R12: `cfg_rdata` reads the limit codes and the command bits in the layout above. The whole register is 0 after power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| crc_err | input | 1 | One-cycle pulse per received CRC error |
| retry_ok | input | 1 | One-cycle pulse when a replay completed cleanly |
| link_up | input | 1 | Link trained level |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 6 | Control register write data |
| cfg_rdata | output | 6 | Control register read data |
| retry_req | output | 1 | One-cycle replay request |
| link_rst_req | output | 1 | One-cycle link reset request |
| err_flag | output | 1 | Sticky fatal recovery error |

## Verification
The bound checker checks these rules on every cycle:
- The command bits clear themselves and each command's effect follows one cycle later.
- The error flag is sticky, stays quiet while set, and rises only after a CRC error.
- The two requests never coincide, and no retry request appears without a sampled CRC error.
- Link-down cycles are ignored, and the replay count stays within its bound.

Only the bench's scenarios can show the counting itself:
- The exact number of replays allowed under each code.
- The escalation ladder up to the error flag.
- The late application of edited codes.
- The train-then-succeed sequence that forgives earlier link resets.

// File: rtl/rec_pkg.sv
package rec_pkg;
  localparam int CFG_W    = 6;
  localparam int RTRY_LSB = 0;
  localparam int LRST_LSB = 2;
  localparam int SOFT_BIT = 4;
  localparam int HARD_BIT = 5;

  typedef logic [1:0] lim_code_t;

  localparam lim_code_t RTRY_OFF = 2'b11;

  typedef struct packed {
    lim_code_t lrst_code;
    lim_code_t rtry_code;
  } rec_cfg_t;
endpackage

// File: rtl/rec_ctrl_reg.sv
module rec_ctrl_reg
  import rec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             hard_go,
  output logic             soft_go,
  output rec_cfg_t         cfg,
  output logic [CFG_W-1:0] cfg_rdata
);
  rec_cfg_t cfg_q, cfg_d;
  logic     hard_q, hard_d;
  logic     soft_q, soft_d;

  // Sticky limit fields: only power-on or an executing hard command clears them.
  always_comb begin
    cfg_d = cfg_q;
    if (hard_q) begin
      cfg_d = '0;
    end else if (cfg_we) begin
      cfg_d.rtry_code = cfg_wdata[RTRY_LSB +: 2];
      cfg_d.lrst_code = cfg_wdata[LRST_LSB +: 2];
    end
  end

  // Command bits live for exactly one cycle; the reset executes on the next edge.
  always_comb begin
    hard_d = cfg_we & cfg_wdata[HARD_BIT];
    soft_d = cfg_we & cfg_wdata[SOFT_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      hard_q <= 1'b0;
      soft_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      hard_q <= hard_d;
      soft_q <= soft_d;
    end
  end

  assign hard_go   = hard_q;
  assign soft_go   = soft_q;
  assign cfg       = cfg_q;
  assign cfg_rdata = {hard_q, soft_q, cfg_q.lrst_code, cfg_q.rtry_code};
endmodule

// File: rtl/rec_sat_counter.sv
module rec_sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && (cnt_q != TOP)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rec_escalate_fsm.sv
module rec_escalate_fsm
  import rec_pkg::*;
#(
  parameter int RTRY_MAX = 16,
  parameter int LRST_MAX = 2,
  parameter int RCNT_W   = 5,
  parameter int LCNT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crc_err,
  input  logic              retry_ok,
  input  logic              link_up,
  input  logic              hard_go,
  input  logic              soft_go,
  input  rec_cfg_t          cfg,
  input  logic [RCNT_W-1:0] rcnt,
  input  logic [LCNT_W-1:0] lcnt,
  output logic              rcnt_inc,
  output logic              rcnt_clr,
  output logic              lcnt_inc,
  output logic              lcnt_clr,
  output logic              retry_req,
  output logic              link_rst_req,
  output logic              err_flag
);
  // Limit decode: each code step halves the allowance.
  function automatic logic [RCNT_W-1:0] rtry_lim(input lim_code_t c);
    return RCNT_W'(RTRY_MAX >> c);
  endfunction

  // The reserved top code is treated as "no link reset allowed".
  function automatic logic [LCNT_W-1:0] lrst_lim(input lim_code_t c);
    return (c == 2'b11) ? '0 : LCNT_W'(LRST_MAX >> c);
  endfunction

  localparam logic [RCNT_W-1:0] RLIM_DEF = rtry_lim(2'b00);
  localparam logic [LCNT_W-1:0] LLIM_DEF = lrst_lim(2'b00);

  logic [RCNT_W-1:0] sh_rlim_q, sh_rlim_d;
  logic              sh_rdis_q, sh_rdis_d;
  logic [LCNT_W-1:0] sh_llim_q, sh_llim_d;
  logic              err_q, err_d;
  logic              await_q, await_d;
  logic              trained_q, trained_d;
  logic              link_q;
  logic              rreq_q, rreq_d;
  logic              lreq_q, lreq_d;
  logic              link_rise;

  assign link_rise = link_up & ~link_q;

  always_comb begin
    sh_rlim_d = sh_rlim_q;
    sh_rdis_d = sh_rdis_q;
    sh_llim_d = sh_llim_q;
    err_d     = err_q;
    await_d   = await_q;
    trained_d = trained_q;
    rreq_d    = 1'b0;
    lreq_d    = 1'b0;
    rcnt_inc  = 1'b0;
    rcnt_clr  = 1'b0;
    lcnt_inc  = 1'b0;
    lcnt_clr  = 1'b0;

    // Link came back up after an escalation reset.
    if (await_q && link_rise) begin
      trained_d = 1'b1;
      await_d   = 1'b0;
    end

    if (hard_go) begin
      rcnt_clr  = 1'b1;
      lcnt_clr  = 1'b1;
      err_d     = 1'b0;
      lreq_d    = 1'b1;
      sh_rlim_d = RLIM_DEF;
      sh_rdis_d = 1'b0;
      sh_llim_d = LLIM_DEF;
      await_d   = 1'b0;
      trained_d = 1'b0;
    end else if (soft_go) begin
      if (!err_q) begin
        rcnt_clr  = 1'b1;
        lreq_d    = 1'b1;
        sh_rlim_d = rtry_lim(cfg.rtry_code);
        sh_rdis_d = (cfg.rtry_code == RTRY_OFF);
        sh_llim_d = lrst_lim(cfg.lrst_code);
      end
    end else if (crc_err && link_up && !err_q) begin
      if (sh_rdis_q) begin
        err_d = 1'b1;
      end else if (rcnt < sh_rlim_q) begin
        rcnt_inc = 1'b1;
        rreq_d   = 1'b1;
      end else begin
        rcnt_clr = 1'b1;
        if (lcnt < sh_llim_q) begin
          lcnt_inc  = 1'b1;
          lreq_d    = 1'b1;
          sh_rlim_d = rtry_lim(cfg.rtry_code);
          sh_rdis_d = (cfg.rtry_code == RTRY_OFF);
          sh_llim_d = lrst_lim(cfg.lrst_code);
          await_d   = 1'b1;
          trained_d = 1'b0;
        end else begin
          err_d = 1'b1;
        end
      end
    end else if (retry_ok && !err_q) begin
      rcnt_clr = 1'b1;
      if (trained_q) begin
        lcnt_clr  = 1'b1;
        trained_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_rlim_q <= RLIM_DEF;
      sh_rdis_q <= 1'b0;
      sh_llim_q <= LLIM_DEF;
      err_q     <= 1'b0;
      await_q   <= 1'b0;
      trained_q <= 1'b0;
      link_q    <= 1'b0;
      rreq_q    <= 1'b0;
      lreq_q    <= 1'b0;
    end else begin
      sh_rlim_q <= sh_rlim_d;
      sh_rdis_q <= sh_rdis_d;
      sh_llim_q <= sh_llim_d;
      err_q     <= err_d;
      await_q   <= await_d;
      trained_q <= trained_d;
      link_q    <= link_up;
      rreq_q    <= rreq_d;
      lreq_q    <= lreq_d;
    end
  end

  assign retry_req    = rreq_q;
  assign link_rst_req = lreq_q;
  assign err_flag     = err_q;
endmodule

// File: rtl/retry_escalation_ctrl.sv
module retry_escalation_ctrl
  import rec_pkg::*;
#(
  parameter int RTRY_MAX = 16,
  parameter int LRST_MAX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             crc_err,
  input  logic             retry_ok,
  input  logic             link_up,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             retry_req,
  output logic             link_rst_req,
  output logic             err_flag
);
  localparam int RCNT_W = $clog2(RTRY_MAX + 1);
  localparam int LCNT_W = $clog2(LRST_MAX + 1);

  rec_cfg_t          cfg;
  logic              hard_go, soft_go;
  logic [RCNT_W-1:0] rtry_cnt;
  logic [LCNT_W-1:0] lrst_cnt;
  logic              rcnt_inc, rcnt_clr, lcnt_inc, lcnt_clr;

  rec_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .hard_go   (hard_go),
    .soft_go   (soft_go),
    .cfg       (cfg),
    .cfg_rdata (cfg_rdata)
  );

  rec_sat_counter #(.W(RCNT_W)) u_rtry_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rcnt_clr),
    .inc   (rcnt_inc),
    .cnt   (rtry_cnt)
  );

  rec_sat_counter #(.W(LCNT_W)) u_lrst_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (lcnt_clr),
    .inc   (lcnt_inc),
    .cnt   (lrst_cnt)
  );

  rec_escalate_fsm #(
    .RTRY_MAX (RTRY_MAX),
    .LRST_MAX (LRST_MAX),
    .RCNT_W   (RCNT_W),
    .LCNT_W   (LCNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .crc_err      (crc_err),
    .retry_ok     (retry_ok),
    .link_up      (link_up),
    .hard_go      (hard_go),
    .soft_go      (soft_go),
    .cfg          (cfg),
    .rcnt         (rtry_cnt),
    .lcnt         (lrst_cnt),
    .rcnt_inc     (rcnt_inc),
    .rcnt_clr     (rcnt_clr),
    .lcnt_inc     (lcnt_inc),
    .lcnt_clr     (lcnt_clr),
    .retry_req    (retry_req),
    .link_rst_req (link_rst_req),
    .err_flag     (err_flag)
  );
endmodule

// File: rtl/rec_chk.sv
module rec_chk #(
  parameter int RCNT_W   = 5,
  parameter int RTRY_MAX = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              crc_err,
  input logic              link_up,
  input logic              cfg_we,
  input logic              wr_hard,
  input logic [5:0]        cfg_rdata,
  input logic              retry_req,
  input logic              link_rst_req,
  input logic              err_flag,
  input logic [RCNT_W-1:0] rcnt
);
  // R1
  retry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> ($past(crc_err) && $past(link_up)));

  // R1
  rcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rcnt) <= RTRY_MAX);

  // R2
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_req && link_rst_req));

  // R3
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(crc_err));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !cfg_rdata[5]) |=> err_flag);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !cfg_rdata[5]) |=> (!retry_req && !link_rst_req));

  // R9
  soft_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[4] && !cfg_rdata[5] && !err_flag) |=> link_rst_req);

  // R10
  hard_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[5] |=> (link_rst_req && !err_flag && (cfg_rdata[3:0] == 4'd0)));

  // R10
  hard_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[5] && !(cfg_we && wr_hard)) |=> !cfg_rdata[5]);

  // R11
  down_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && !cfg_rdata[4] && !cfg_rdata[5])
      |=> (!retry_req && !link_rst_req && $stable(err_flag)));
endmodule

bind retry_escalation_ctrl rec_chk #(
  .RCNT_W   (RCNT_W),
  .RTRY_MAX (RTRY_MAX)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .crc_err      (crc_err),
  .link_up      (link_up),
  .cfg_we       (cfg_we),
  .wr_hard      (cfg_wdata[5]),
  .cfg_rdata    (cfg_rdata),
  .retry_req    (retry_req),
  .link_rst_req (link_rst_req),
  .err_flag     (err_flag),
  .rcnt         (rtry_cnt)
);

// File: tb/retry_escalation_ctrl_tb.sv
module retry_escalation_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic       crc_err;
  logic       retry_ok;
  logic       link_up;
  logic       cfg_we;
  logic [5:0] cfg_wdata;
  logic [5:0] cfg_rdata;
  logic       retry_req;
  logic       link_rst_req;
  logic       err_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  retry_escalation_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .crc_err      (crc_err),
    .retry_ok     (retry_ok),
    .link_up      (link_up),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .retry_req    (retry_req),
    .link_rst_req (link_rst_req),
    .err_flag     (err_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // One CRC error; outputs sampled one cycle after it is sampled.
  task automatic crc(input bit er, input bit el, input bit ee, input string req);
    @(negedge clk);
    crc_err = 1'b1;
    @(negedge clk);
    crc_err = 1'b0;
    chk(retry_req == er,    {req, " retry_req"},    int'(retry_req),    int'(er));
    chk(link_rst_req == el, {req, " link_rst_req"}, int'(link_rst_req), int'(el));
    chk(err_flag == ee,     {req, " err_flag"},     int'(err_flag),     int'(ee));
  endtask

  task automatic retries(input int n, input string req);
    for (int i = 0; i < n; i++) crc(1'b1, 1'b0, 1'b0, req);
  endtask

  task automatic ok_pulse();
    @(negedge clk);
    retry_ok = 1'b1;
    @(negedge clk);
    retry_ok = 1'b0;
  endtask

  task automatic cmd_hard();
    wr(6'b100000);
    chk(cfg_rdata[5] == 1'b1, "R10 hard bit set", int'(cfg_rdata[5]), 1);
    @(negedge clk);
    chk(link_rst_req == 1'b1, "R10 hard link_rst_req", int'(link_rst_req), 1);
    chk(err_flag == 1'b0,     "R10 hard clears err",   int'(err_flag), 0);
    chk(cfg_rdata == 6'd0,    "R10 hard clears reg",   int'(cfg_rdata), 0);
  endtask

  task automatic cmd_soft(input logic [3:0] f, input bit exp_lr);
    wr({2'b01, f});
    @(negedge clk);
    chk(link_rst_req == exp_lr, "R9 soft link_rst_req", int'(link_rst_req), int'(exp_lr));
    chk(cfg_rdata == {2'b00, f}, "R9 soft keeps fields, bit clears", int'(cfg_rdata), int'({2'b00, f}));
  endtask

  task automatic t_reset();
    chk(cfg_rdata == 6'd0, "R12 reset reg", int'(cfg_rdata), 0);
    chk(!retry_req && !link_rst_req && !err_flag, "R12 reset outputs",
        int'({retry_req, link_rst_req, err_flag}), 0);
  endtask

  task automatic t_default();
    cmd_hard();
    retries(16, "R1 code00");
    crc(1'b0, 1'b1, 1'b0, "R2 escalate");
    crc(1'b1, 1'b0, 1'b0, "R2 count restart");
  endtask

  task automatic t_codes();
    cmd_hard();
    wr(6'b000001);
    chk(cfg_rdata == 6'b000001, "R12 readback", int'(cfg_rdata), 1);
    retries(10, "R8 late action old limit");
    cmd_soft(4'b0001, 1'b1);
    retries(8, "R1 code01");
    crc(1'b0, 1'b1, 1'b0, "R1 code01 limit");
    cmd_soft(4'b0010, 1'b1);
    retries(4, "R1 code10");
    crc(1'b0, 1'b1, 1'b0, "R1 code10 limit");
  endtask

  task automatic t_ok_clear();
    cmd_hard();
    retries(10, "R5 pre");
    ok_pulse();
    retries(16, "R5 after ok");
    crc(1'b0, 1'b1, 1'b0, "R5 escalate");
  endtask

  task automatic t_lrst();
    cmd_hard();
    cmd_soft(4'b0010, 1'b1);
    for (int k = 0; k < 2; k++) begin
      retries(4, "R4 code00");
      crc(1'b0, 1'b1, 1'b0, "R4 code00 reset");
    end
    retries(4, "R4 code00");
    crc(1'b0, 1'b0, 1'b1, "R4 code00 error");
    crc(1'b0, 1'b0, 1'b1, "R7 quiet on crc");
    cmd_soft(4'b0010, 1'b0);
    chk(err_flag == 1'b1, "R7 err survives soft", int'(err_flag), 1);
    cmd_hard();
    cmd_soft(4'b0110, 1'b1);
    retries(4, "R4 code01");
    crc(1'b0, 1'b1, 1'b0, "R4 code01 reset");
    retries(4, "R4 code01");
    crc(1'b0, 1'b0, 1'b1, "R4 code01 error");
    cmd_hard();
    cmd_soft(4'b1010, 1'b1);
    retries(4, "R4 code10");
    crc(1'b0, 1'b0, 1'b1, "R4 code10 error");
    cmd_hard();
    cmd_soft(4'b1110, 1'b1);
    retries(4, "R4 code11");
    crc(1'b0, 1'b0, 1'b1, "R4 code11 error");
  endtask

  task automatic t_disable();
    cmd_hard();
    cmd_soft(4'b0011, 1'b1);
    crc(1'b0, 1'b0, 1'b1, "R3 first crc");
    crc(1'b0, 1'b0, 1'b1, "R3 second crc");
  endtask

  task automatic t_train();
    cmd_hard();
    cmd_soft(4'b0010, 1'b1);
    for (int k = 0; k < 2; k++) begin
      retries(4, "R6 pre");
      crc(1'b0, 1'b1, 1'b0, "R6 reset");
    end
    ok_pulse();
    retries(4, "R6 no training");
    crc(1'b0, 1'b0, 1'b1, "R6 no forgive");
    cmd_hard();
    cmd_soft(4'b0010, 1'b1);
    for (int k = 0; k < 2; k++) begin
      retries(4, "R6 pre");
      crc(1'b0, 1'b1, 1'b0, "R6 reset");
    end
    @(negedge clk);
    link_up = 1'b0;
    @(negedge clk);
    link_up = 1'b1;
    ok_pulse();
    retries(4, "R6 trained");
    crc(1'b0, 1'b1, 1'b0, "R6 forgiven");
  endtask

  task automatic t_down();
    cmd_hard();
    cmd_soft(4'b0010, 1'b1);
    retries(2, "R11 pre");
    @(negedge clk);
    link_up = 1'b0;
    for (int k = 0; k < 3; k++) crc(1'b0, 1'b0, 1'b0, "R11 down");
    @(negedge clk);
    link_up = 1'b1;
    retries(2, "R11 after");
    crc(1'b0, 1'b1, 1'b0, "R11 count kept");
  endtask

  task automatic t_hard_defaults();
    cmd_hard();
    cmd_soft(4'b1111, 1'b1);
    cmd_hard();
    retries(16, "R8 hard defaults");
    crc(1'b0, 1'b1, 1'b0, "R8 hard defaults limit");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    crc_err   = 1'b0;
    retry_ok  = 1'b0;
    link_up   = 1'b1;
    cfg_we    = 1'b0;
    cfg_wdata = 6'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default();
    t_codes();
    t_ok_clear();
    t_lrst();
    t_disable();
    t_train();
    t_down();
    t_hard_defaults();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule